// File: doc/BRIEF.md
# IN Endpoint Transmit Bank Manager

This block keeps track of a ring of transmit data banks (two by default, used ping-pong) for one USB device IN endpoint. Firmware fills the bank named by `fillBank` and commits it with a one-cycle strobe. The serial side sends committed banks in the order they were committed. It opens a read on the oldest busy bank when the host asks for data and frees that bank when the read finishes. The number of busy banks is always visible to the CPU.

To drop pending data, firmware first turns off the transmit-ready interrupt enable. It then issues a kill command, which retracts the most recently committed bank that has not been sent. The kill status bit stays high while the kill is in progress and clears by itself. Firmware repeats the kill after each one clears, until the busy count reads zero. In isochronous mode, a host read that finds no busy bank sets a sticky underflow flag. All signalling is at packet level. Token decoding, CRC, the serial engine and the byte RAM sit outside this block.

Top module: `ep_in_bank_mgr`

## Requirements
- R1: After synchronous reset, `busyCount`, `fillBank`, `drainBank`, `readActive`, `killBusy` and `underflowFlag` are 0 and `txReady` is 1.
- R2: A `commit` strobe while `busyCount` is below the bank count raises `busyCount` by one and advances `fillBank` to the next bank index (0, 1, 0, ...). A commit while all banks are busy changes nothing.
- R3: A `readReq` while at least one bank is busy and no read is open sets `readActive` on bank `drainBank`, which is always the oldest busy bank. A `readDone` during an open read clears `readActive`, lowers `busyCount` by one and advances `drainBank`.
- R4: An accepted kill removes the newest committed bank. `busyCount` drops by one, `fillBank` steps back to the removed bank's index, and `drainBank` keeps its value. The count changes at the clock edge that accepts the command.
- R5: An accepted kill holds `killBusy` high for exactly two cycles after the accepting edge, and then it clears by itself. A `killCmd` while `killBusy` is high is ignored. A kill while no bank is busy runs its two cycles and changes no bank state.
- R6: When exactly one bank is busy and its read is open or starts in the same cycle, a kill is accepted (`killBusy` pulses) but removes nothing, and the read proceeds. When two banks are busy, a read starting on the oldest bank and a kill of the newest bank both take effect in the same cycle.
- R7: If `commit` and `killCmd` are asserted in the same cycle, the commit is processed and the kill is ignored (`killBusy` stays low).
- R8: With `isoMode` high, a `readReq` while `busyCount` is 0 and no read is open sets `underflowFlag`. The flag stays set until a `clrUnder` strobe, and a set in the same cycle as a clear wins. With `isoMode` low, no underflow is flagged.
- R9: `txReady` is high whenever at least one bank is free. `txIrq` is `txReady` gated by `txIrqEn`.
- R10: A `readReq` during an open read is ignored, and a `readDone` with no open read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| isoMode | input | 1 | Endpoint is isochronous (enables underflow detection) |
| commit | input | 1 | CPU strobe: bank at `fillBank` is filled and handed over |
| readReq | input | 1 | USB strobe: host requests data (start read of oldest bank) |
| readDone | input | 1 | USB strobe: open read completed, bank freed |
| killCmd | input | 1 | CPU strobe: write of one to the kill command bit |
| txIrqEn | input | 1 | Transmit-ready interrupt enable |
| clrUnder | input | 1 | CPU write-one strobe clearing the underflow flag |
| busyCount | output | $clog2(NUM_BANKS+1) | Number of committed, unsent banks |
| fillBank | output | $clog2(NUM_BANKS) | Index of the bank the CPU fills next |
| drainBank | output | $clog2(NUM_BANKS) | Index of the oldest busy bank |
| readActive | output | 1 | A host read of `drainBank` is open |
| killBusy | output | 1 | Kill command bit, self-clearing |
| txReady | output | 1 | At least one bank is free |
| txIrq | output | 1 | Transmit-ready interrupt request |
| underflowFlag | output | 1 | Sticky isochronous underflow flag |

## Verification
The properties assume `readDone` is asserted only while a read is open, and that each strobe lasts one cycle per event. They also assume firmware never commits and kills in the same cycle on purpose. The bench drives every strobe as a single-cycle pulse, away from the clock edge. It asserts `readDone` only after `readActive` has been seen high, except in the one deliberate check of R10. It drives the commit-and-kill collision only in the scenario that checks R7.

// File: rtl/ep_bank_pkg.sv
package ep_bank_pkg;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic doCommit;   // take a new bank into the ring
    logic startRead;  // open host read on oldest bank
    logic finishRead; // release oldest bank
    logic killHit;    // retract newest bank
    logic setUnder;   // raise isochronous underflow
  } bankCtl_t;

endpackage

// File: rtl/ep_bank_ctrl.sv
module ep_bank_ctrl
  import ep_bank_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int KILL_CYCLES = 2,
  localparam int CNT_W      = $clog2(NUM_BANKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             isoMode,
  input  logic             commit,
  input  logic             readReq,
  input  logic             readDone,
  input  logic             killCmd,
  input  logic [CNT_W-1:0] busyCount,
  input  logic             readActive,
  output bankCtl_t         ctl,
  output logic             killBusy
);

  localparam int TMR_W = $clog2(KILL_CYCLES + 1);

  logic [TMR_W-1:0] killTmr;
  logic             ringEmpty;
  logic             ringFull;
  logic             singleBusy;
  logic             killAccept;

  assign ringEmpty  = (busyCount == '0);
  assign ringFull   = (busyCount == CNT_W'(NUM_BANKS));
  assign singleBusy = (busyCount == CNT_W'(1));

  // Commit outranks a kill in the same cycle; a running kill blocks a new one
  assign killAccept = killCmd && !killBusy && !commit;

  always_comb begin
    ctl            = '0;
    ctl.doCommit   = commit && !ringFull;
    ctl.startRead  = readReq && !readActive && !ringEmpty;
    ctl.finishRead = readDone && readActive;
    // Newest bank equals the one being read when only one is busy: read wins
    ctl.killHit    = killAccept && !ringEmpty &&
                     !(singleBusy && (readActive || ctl.startRead));
    ctl.setUnder   = readReq && !readActive && ringEmpty && isoMode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      killTmr <= '0;
    end else if (killAccept) begin
      killTmr <= TMR_W'(KILL_CYCLES);
    end else if (killTmr != '0) begin
      killTmr <= killTmr - 1'b1;
    end
  end

  assign killBusy = (killTmr != '0);

endmodule

// File: rtl/ep_bank_dp.sv
module ep_bank_dp
  import ep_bank_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  localparam int CNT_W    = $clog2(NUM_BANKS + 1),
  localparam int PTR_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  bankCtl_t         ctl,
  input  logic             clrUnder,
  output logic [CNT_W-1:0] busyCount,
  output logic [PTR_W-1:0] fillBank,
  output logic [PTR_W-1:0] drainBank,
  output logic             readActive,
  output logic             underflowFlag,
  output logic             txReady
);

  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NUM_BANKS - 1);

  function automatic logic [PTR_W-1:0] ptrNext(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptrPrev(input logic [PTR_W-1:0] p);
    return (p == '0) ? LAST_IDX : p - 1'b1;
  endfunction

  logic [CNT_W-1:0] cntNext;

  always_comb begin
    cntNext = busyCount;
    if (ctl.doCommit)   cntNext = cntNext + 1'b1;
    if (ctl.finishRead) cntNext = cntNext - 1'b1;
    if (ctl.killHit)    cntNext = cntNext - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busyCount     <= '0;
      fillBank      <= '0;
      drainBank     <= '0;
      readActive    <= 1'b0;
      underflowFlag <= 1'b0;
    end else begin
      busyCount <= cntNext;
      if (ctl.doCommit)      fillBank <= ptrNext(fillBank);
      else if (ctl.killHit)  fillBank <= ptrPrev(fillBank);
      if (ctl.finishRead)    drainBank <= ptrNext(drainBank);
      if (ctl.startRead)       readActive <= 1'b1;
      else if (ctl.finishRead) readActive <= 1'b0;
      if (ctl.setUnder)      underflowFlag <= 1'b1;
      else if (clrUnder)     underflowFlag <= 1'b0;
    end
  end

  assign txReady = (busyCount != CNT_W'(NUM_BANKS));

endmodule

// File: rtl/ep_in_bank_mgr.sv
module ep_in_bank_mgr
  import ep_bank_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int KILL_CYCLES = 2,
  localparam int CNT_W      = $clog2(NUM_BANKS + 1),
  localparam int PTR_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             isoMode,
  input  logic             commit,
  input  logic             readReq,
  input  logic             readDone,
  input  logic             killCmd,
  input  logic             txIrqEn,
  input  logic             clrUnder,
  output logic [CNT_W-1:0] busyCount,
  output logic [PTR_W-1:0] fillBank,
  output logic [PTR_W-1:0] drainBank,
  output logic             readActive,
  output logic             killBusy,
  output logic             txReady,
  output logic             txIrq,
  output logic             underflowFlag
);

  bankCtl_t ctl;

  ep_bank_ctrl #(
    .NUM_BANKS  (NUM_BANKS),
    .KILL_CYCLES(KILL_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .isoMode   (isoMode),
    .commit    (commit),
    .readReq   (readReq),
    .readDone  (readDone),
    .killCmd   (killCmd),
    .busyCount (busyCount),
    .readActive(readActive),
    .ctl       (ctl),
    .killBusy  (killBusy)
  );

  ep_bank_dp #(
    .NUM_BANKS(NUM_BANKS)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .ctl          (ctl),
    .clrUnder     (clrUnder),
    .busyCount    (busyCount),
    .fillBank     (fillBank),
    .drainBank    (drainBank),
    .readActive   (readActive),
    .underflowFlag(underflowFlag),
    .txReady      (txReady)
  );

  assign txIrq = txReady && txIrqEn;

endmodule

// File: rtl/ep_in_bank_mgr_chk.sv
module ep_in_bank_mgr_chk #(
  parameter int NUM_BANKS = 2,
  localparam int CNT_W    = $clog2(NUM_BANKS + 1),
  localparam int PTR_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             isoMode,
  input logic             commit,
  input logic             readReq,
  input logic             readDone,
  input logic             killCmd,
  input logic [CNT_W-1:0] busyCount,
  input logic [PTR_W-1:0] fillBank,
  input logic [PTR_W-1:0] drainBank,
  input logic             readActive,
  input logic             killBusy,
  input logic             underflowFlag
);

  // R2: count never exceeds the number of banks
  a_r2_count_range: assert property (@(posedge clk) disable iff (rst)
    busyCount <= CNT_W'(NUM_BANKS));

  // R2: accepted commit without a concurrent release bumps the count
  a_r2_commit_inc: assert property (@(posedge clk) disable iff (rst)
    (commit && busyCount < CNT_W'(NUM_BANKS) && !(readDone && readActive))
    |=> busyCount == CNT_W'($past(busyCount) + 1'b1));

  // R4: kill with all banks busy and no open read drops the newest only
  a_r4_kill_newest: assert property (@(posedge clk) disable iff (rst)
    (killCmd && !killBusy && !commit && !readReq && !readActive &&
     busyCount == CNT_W'(NUM_BANKS))
    |=> (busyCount == CNT_W'($past(busyCount) - 1'b1)) &&
        (drainBank == $past(drainBank)) && (fillBank != $past(fillBank)));

  // R5: kill bit rises for a fresh command, then self-clears after two cycles
  a_r5_kill_first: assert property (@(posedge clk) disable iff (rst)
    (killBusy && !$past(killBusy)) |=> killBusy);

  a_r5_kill_second: assert property (@(posedge clk) disable iff (rst)
    (killBusy && $past(killBusy)) |=> !killBusy);

  // R8: empty isochronous host read raises the underflow flag
  a_r8_underflow_set: assert property (@(posedge clk) disable iff (rst)
    (isoMode && readReq && !readActive && busyCount == '0) |=> underflowFlag);

endmodule

bind ep_in_bank_mgr ep_in_bank_mgr_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .isoMode      (isoMode),
  .commit       (commit),
  .readReq      (readReq),
  .readDone     (readDone),
  .killCmd      (killCmd),
  .busyCount    (busyCount),
  .fillBank     (fillBank),
  .drainBank    (drainBank),
  .readActive   (readActive),
  .killBusy     (killBusy),
  .underflowFlag(underflowFlag)
);

// File: tb/tb_ep_in_bank_mgr.sv
module tb_ep_in_bank_mgr;

  logic       clk = 1'b0;
  logic       rst;
  logic       isoMode, commit, readReq, readDone, killCmd, txIrqEn, clrUnder;
  logic [1:0] busyCount;
  logic [0:0] fillBank, drainBank;
  logic       readActive, killBusy, txReady, txIrq, underflowFlag;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;  // 50 MHz

  ep_in_bank_mgr dut (
    .clk(clk), .rst(rst), .isoMode(isoMode), .commit(commit),
    .readReq(readReq), .readDone(readDone), .killCmd(killCmd),
    .txIrqEn(txIrqEn), .clrUnder(clrUnder), .busyCount(busyCount),
    .fillBank(fillBank), .drainBank(drainBank), .readActive(readActive),
    .killBusy(killBusy), .txReady(txReady), .txIrq(txIrq),
    .underflowFlag(underflowFlag)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // advance one edge, settle 1 ns past it
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    commit = 0; readReq = 0; readDone = 0; killCmd = 0; clrUnder = 0;
  endtask

  task automatic pulse(input bit c, input bit rq, input bit rd, input bit k, input bit clr);
    commit = c; readReq = rq; readDone = rd; killCmd = k; clrUnder = clr;
    tick();
    idle();
  endtask

  task automatic t_reset();
    chk("R1", "busyCount", busyCount, 0);
    chk("R1", "fillBank", fillBank, 0);
    chk("R1", "drainBank", drainBank, 0);
    chk("R1", "readActive", readActive, 0);
    chk("R1", "killBusy", killBusy, 0);
    chk("R1", "underflowFlag", underflowFlag, 0);
    chk("R1", "txReady", txReady, 1);
  endtask

  task automatic t_commit();
    pulse(1, 0, 0, 0, 0);
    chk("R2", "count after 1st commit", busyCount, 1);
    chk("R2", "fillBank after 1st commit", fillBank, 1);
    chk("R9", "txReady one free", txReady, 1);
    pulse(1, 0, 0, 0, 0);
    chk("R2", "count after 2nd commit", busyCount, 2);
    chk("R2", "fillBank wraps", fillBank, 0);
    chk("R9", "txReady full", txReady, 0);
    chk("R9", "txIrq full", txIrq, 0);
    pulse(1, 0, 0, 0, 0);
    chk("R2", "commit when full ignored", busyCount, 2);
    chk("R2", "fillBank unchanged when full", fillBank, 0);
  endtask

  task automatic t_drain();
    pulse(0, 1, 0, 0, 0);
    chk("R3", "read opens", readActive, 1);
    chk("R3", "drains bank 0 first", drainBank, 0);
    pulse(0, 1, 0, 0, 0);
    chk("R10", "readReq during read ignored", busyCount, 2);
    chk("R10", "drainBank kept", drainBank, 0);
    pulse(0, 0, 1, 0, 0);
    chk("R3", "count after done", busyCount, 1);
    chk("R3", "drainBank advances", drainBank, 1);
    chk("R3", "read closed", readActive, 0);
    pulse(0, 0, 1, 0, 0);
    chk("R10", "stray readDone ignored", busyCount, 1);
    pulse(0, 1, 0, 0, 0);
    pulse(0, 0, 1, 0, 0);
    chk("R3", "count after second read", busyCount, 0);
    chk("R3", "drainBank wraps", drainBank, 0);
    chk("R9", "txIrq with enable", txIrq, 1);
    txIrqEn = 0;
    #1;
    chk("R9", "txIrq gated", txIrq, 0);
    txIrqEn = 1;
  endtask

  task automatic t_kill();
    pulse(1, 0, 0, 0, 0);
    pulse(1, 0, 0, 0, 0);
    pulse(0, 0, 0, 1, 0);
    chk("R4", "count after kill", busyCount, 1);
    chk("R4", "fillBank steps back", fillBank, 1);
    chk("R4", "drainBank kept", drainBank, 0);
    chk("R5", "killBusy cycle 1", killBusy, 1);
    pulse(0, 0, 0, 1, 0);
    chk("R5", "kill while busy ignored", busyCount, 1);
    chk("R5", "killBusy cycle 2", killBusy, 1);
    tick();
    chk("R5", "killBusy self-clears", killBusy, 0);
    pulse(0, 0, 0, 1, 0);
    chk("R4", "second kill empties", busyCount, 0);
    chk("R4", "fillBank back to 0", fillBank, 0);
    tick(); tick();
    chk("R5", "killBusy clear", killBusy, 0);
    pulse(0, 0, 0, 1, 0);
    chk("R5", "kill at zero runs", killBusy, 1);
    chk("R5", "kill at zero no effect", busyCount, 0);
    tick();
    chk("R5", "kill at zero still busy", killBusy, 1);
    tick();
    chk("R5", "kill at zero clears", killBusy, 0);
    chk("R5", "fillBank untouched", fillBank, 0);
  endtask

  task automatic t_collide();
    pulse(1, 0, 0, 0, 0);
    pulse(0, 1, 0, 1, 0);
    chk("R6", "same-bank read wins", busyCount, 1);
    chk("R6", "read opened", readActive, 1);
    chk("R6", "kill still accepted", killBusy, 1);
    tick(); tick();
    pulse(0, 0, 0, 1, 0);
    chk("R6", "kill during read of only bank", busyCount, 1);
    chk("R6", "fillBank kept", fillBank, 1);
    tick(); tick();
    pulse(0, 0, 1, 0, 0);
    chk("R6", "read completes", busyCount, 0);
    chk("R6", "drainBank advanced", drainBank, 1);
    pulse(1, 0, 0, 0, 0);
    pulse(1, 0, 0, 0, 0);
    chk("R6", "two busy", busyCount, 2);
    pulse(0, 1, 0, 1, 0);
    chk("R6", "read and kill both act", busyCount, 1);
    chk("R6", "fillBank retracted", fillBank, 0);
    chk("R6", "read on oldest", drainBank, 1);
    chk("R6", "read open", readActive, 1);
    pulse(0, 0, 1, 0, 0);
    chk("R6", "all drained", busyCount, 0);
    chk("R6", "drainBank meets fillBank", drainBank, 0);
    tick();
  endtask

  task automatic t_commit_kill();
    pulse(1, 0, 0, 1, 0);
    chk("R7", "commit taken", busyCount, 1);
    chk("R7", "kill ignored", killBusy, 0);
    pulse(0, 0, 0, 1, 0);
    chk("R7", "cleanup kill", busyCount, 0);
    tick(); tick();
  endtask

  task automatic t_underflow();
    isoMode = 0;
    pulse(0, 1, 0, 0, 0);
    chk("R8", "no flag when not iso", underflowFlag, 0);
    isoMode = 1;
    pulse(0, 1, 0, 0, 0);
    chk("R8", "flag set", underflowFlag, 1);
    chk("R8", "no read opened", readActive, 0);
    tick();
    chk("R8", "flag sticky", underflowFlag, 1);
    pulse(0, 0, 0, 0, 1);
    chk("R8", "flag cleared", underflowFlag, 0);
    pulse(0, 1, 0, 0, 1);
    chk("R8", "set wins over clear", underflowFlag, 1);
    pulse(0, 0, 0, 0, 1);
    chk("R8", "cleared again", underflowFlag, 0);
  endtask

  initial begin
    rst = 1; isoMode = 0; txIrqEn = 1;
    idle();
    tick(); tick();
    rst = 0;
    #1;
    t_reset();
    t_commit();
    t_drain();
    t_kill();
    t_collide();
    t_commit_kill();
    t_underflow();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule